// File: doc/BRIEF.md
# Three-Bit Lookahead Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It works on two 3-bit two's-complement operands and returns a 3-bit result. A 2-bit operation code chooses one of four functions:
- bitwise AND of the operands;
- bitwise OR of the operands;
- the complement of the first operand;
- an add/subtract path.

On the add/subtract path, the carry input does two jobs. It selects between addition and subtraction, and it is also the carry into the least significant bit.

All carries come from one three-bit lookahead group. Each bit forms a generate term and a propagate term, and every internal carry, plus the group carry-out, is formed in parallel from those terms. Nothing ripples from bit to bit. The group carry-out is exposed so that several such units can be joined by ripple carry between groups.

Top module: `alu3_top`

## Requirements
- R1: With `op_sel` = 2'b00, `res` equals the bitwise AND of `opa` and `opb`.
- R2: With `op_sel` = 2'b11, `res` equals the bitwise OR of `opa` and `opb`.
- R3: With `op_sel` = 2'b10, `res` equals the bitwise complement of `opa`, and no value of `opb` or `carry_in` changes `res`.
- R4: With `op_sel` = 2'b01 and `carry_in` = 0, `{carry_out, res}` equals the 4-bit sum `opa + opb`. Bit 2 is the most significant bit of every 3-bit vector.
- R5: With `op_sel` = 2'b01 and `carry_in` = 1, `res` equals `(opa - opb) mod 8`, and `carry_out` is bit 3 of `opa + ~opb + 1`. This means `carry_out` is 1 exactly when `opa >= opb` as unsigned values.
- R6: For every logic code (2'b00, 2'b10, 2'b11), `carry_out` is 0.
- R7: The unit holds no state. Outputs follow the present inputs within the same clock period, with no clock and no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 3 | First operand; the only operand of the complement function |
| opb | input | 3 | Second operand |
| op_sel | input | 2 | Operation code: 00 AND, 01 add/subtract, 10 complement of opa, 11 OR |
| carry_in | input | 1 | On the add/subtract path: carry into bit 0 and the subtract request |
| res | output | 3 | Result |
| carry_out | output | 1 | Group carry-out of the lookahead adder; 0 for logic codes |

## Verification
The embedded checks assume that every input carries a known 0 or 1 when they evaluate. They also assume the four operation codes are the whole input space, so no illegal code can exist. The bench drives inputs only on the rising clock edge and reads the outputs on the falling edge, so every input is settled before any check looks at it.

The stimulus first walks a table of hand-computed corner vectors. These include a carry that propagates through all bits, subtraction of equal values, and wrap-around modulo 8. It then sweeps every combination of operands and carry for each operation code, and compares the outputs against a model of the arithmetic written independently in the bench.

// File: rtl/alu3_pkg.sv
package alu3_pkg;
    typedef enum logic [1:0] {
        OP_AND   = 2'b00,
        OP_ARITH = 2'b01,
        OP_NOTA  = 2'b10,
        OP_OR    = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu3_pg.sv
// Per-bit generate/propagate terms; the second operand is inverted on subtract.
module alu3_pg #(
    parameter int W = 3
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic b_eff;
            assign b_eff   = opb[i] ^ sub;
            assign gen[i]  = opa[i] & b_eff;
            assign prop[i] = opa[i] ^ b_eff;
        end
    endgenerate
endmodule

// File: rtl/alu3_cla.sv
// One lookahead group: every carry is a flat sum of products of g/p/cin.
module alu3_cla #(
    parameter int W = 3
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         cin,
    output logic [W:0]   carry
);
    always_comb begin
        carry[0] = cin;
        for (int i = 1; i <= W; i++) begin
            logic acc;
            logic term;
            acc  = 1'b0;
            for (int j = 0; j < i; j++) begin
                term = gen[j];
                for (int k = j + 1; k < i; k++) term = term & prop[k];
                acc = acc | term;
            end
            term = cin;
            for (int k = 0; k < i; k++) term = term & prop[k];
            carry[i] = acc | term;
        end
    end

    // R4: a group that neither generates nor propagates anywhere emits no carry
    always_comb begin
        if (!$isunknown({gen, prop, cin}) && gen == '0 && prop == '0)
            no_carry_chk: assert (carry[W:1] == '0);
    end
endmodule

// File: rtl/alu3_logic.sv
// Bitwise functions for the three logic codes.
module alu3_logic #(
    parameter int W = 3
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  alu3_pkg::alu_op_e op,
    output logic [W-1:0]     res
);
    import alu3_pkg::*;
    always_comb begin
        unique case (op)
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_NOTA: res = ~opa;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu3_top.sv
module alu3_top #(
    parameter int W = 3
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   op_sel,
    input  logic         carry_in,
    output logic [W-1:0] res,
    output logic         carry_out
);
    import alu3_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic         cout;
    } alu_out_t;

    alu_op_e      op;
    logic [W-1:0] gen, prop, logic_res, sum;
    logic [W:0]   carry;
    alu_out_t     out_d;

    assign op = alu_op_e'(op_sel);

    alu3_pg #(.W(W)) u_pg (
        .opa(opa), .opb(opb), .sub(carry_in), .gen(gen), .prop(prop)
    );

    alu3_cla #(.W(W)) u_cla (
        .gen(gen), .prop(prop), .cin(carry_in), .carry(carry)
    );

    alu3_logic #(.W(W)) u_logic (
        .opa(opa), .opb(opb), .op(op), .res(logic_res)
    );

    assign sum = prop ^ carry[W-1:0];

    always_comb begin
        out_d = '0;
        if (op == OP_ARITH) begin
            out_d.res  = sum;
            out_d.cout = carry[W];
        end else begin
            out_d.res  = logic_res;
            out_d.cout = 1'b0;
        end
    end

    assign res       = out_d.res;
    assign carry_out = out_d.cout;

    always_comb begin
        logic [W:0] arith_ref;
        arith_ref = {1'b0, opa} + {1'b0, (carry_in ? ~opb : opb)} + {{W{1'b0}}, carry_in};
        if (!$isunknown({opa, opb, op_sel, carry_in})) begin
            // R4 R5
            if (op == OP_ARITH)
                arith_sum_chk: assert ({carry_out, res} == arith_ref);
            // R6
            if (op != OP_ARITH)
                logic_cout_chk: assert (carry_out == 1'b0);
            // R3
            if (op == OP_NOTA)
                nota_chk: assert ((res ^ opa) == '1);
            // R1
            if (op == OP_AND)
                and_subset_chk: assert ((res & ~opa) == '0 && (res & ~opb) == '0);
            // R2
            if (op == OP_OR)
                or_cover_chk: assert ((opa & ~res) == '0 && (opb & ~res) == '0);
        end
    end
endmodule

// File: tb/alu3_top_bench.sv
module alu3_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] opa = '0, opb = '0;
    logic [1:0] op_sel = '0;
    logic       carry_in = 1'b0;
    logic [2:0] res;
    logic       carry_out;
    int         n_checks = 0, n_fail = 0, cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    alu3_top u_alu3_top (
        .opa(opa), .opb(opb), .op_sel(op_sel), .carry_in(carry_in),
        .res(res), .carry_out(carry_out)
    );

    // vector: {op, a, b, cin, exp_res, exp_cout}
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        {2'b00, 3'd6, 3'd3, 1'b0, 3'd2, 1'b0},  // R1
        {2'b00, 3'd7, 3'd7, 1'b1, 3'd7, 1'b0},  // R1 R6
        {2'b11, 3'd4, 3'd1, 1'b0, 3'd5, 1'b0},  // R2
        {2'b11, 3'd0, 3'd0, 1'b1, 3'd0, 1'b0},  // R2 R6
        {2'b10, 3'd5, 3'd7, 1'b0, 3'd2, 1'b0},  // R3
        {2'b10, 3'd5, 3'd0, 1'b1, 3'd2, 1'b0},  // R3 B and cin ignored
        {2'b01, 3'd3, 3'd2, 1'b0, 3'd5, 1'b0},  // R4
        {2'b01, 3'd7, 3'd1, 1'b0, 3'd0, 1'b1},  // R4 wrap
        {2'b01, 3'd7, 3'd7, 1'b0, 3'd6, 1'b1},  // R4
        {2'b01, 3'd7, 3'd0, 1'b0, 3'd7, 1'b0},  // R4 full propagate
        {2'b01, 3'd5, 3'd2, 1'b1, 3'd3, 1'b1},  // R5
        {2'b01, 3'd2, 3'd5, 1'b1, 3'd5, 1'b0},  // R5 negative
        {2'b01, 3'd0, 3'd0, 1'b1, 3'd0, 1'b1},  // R5
        {2'b01, 3'd3, 3'd3, 1'b1, 3'd0, 1'b1}   // R5 carry through all bits
    };

    task automatic check(input string req, input logic [2:0] er, input logic ec);
        n_checks++;
        if (res !== er || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s: op=%b a=%0d b=%0d cin=%b got res=%0d cout=%b expected res=%0d cout=%b",
                     req, op_sel, opa, opb, carry_in, res, carry_out, er, ec);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [2:0] a, input logic [2:0] b,
                         input logic ci);
        @(posedge clk);
        op_sel = op; opa = a; opb = b; carry_in = ci;
        @(negedge clk);
    endtask

    function automatic string req_of(input logic [1:0] op, input logic ci);
        case (op)
            2'b00:   return "R1";
            2'b11:   return "R2";
            2'b10:   return "R3";
            default: return ci ? "R5" : "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R7: all-zero inputs, no reset in the design: AND of zeros is zero
        check("R7", 3'd0, 1'b0);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][12:11], VEC[v][10:8], VEC[v][7:5], VEC[v][4]);
            check(req_of(VEC[v][12:11], VEC[v][4]), VEC[v][3:1], VEC[v][0]);
        end

        // R7: output follows a change within the same period
        apply(2'b01, 3'd1, 3'd1, 1'b0);
        check("R7", 3'd2, 1'b0);
        apply(2'b11, 3'd1, 3'd2, 1'b0);
        check("R7", 3'd3, 1'b0);

        // exhaustive sweep against an independent model; R6 on logic codes
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 128; k++) begin
                logic [2:0] a, b, er;
                logic       ci, ec;
                int         full;
                a = k[6:4]; b = k[3:1]; ci = k[0];
                ec = 1'b0;
                case (op)
                    0: er = a & b;
                    3: er = a | b;
                    2: er = ~a;
                    default: begin
                        if (ci) full = int'(a) + (8 - int'(b));
                        else    full = int'(a) + int'(b);
                        er = full[2:0];
                        ec = full[3];
                    end
                endcase
                apply(op[1:0], a, b, ci);
                check(op == 1 ? req_of(2'b01, ci) : "R6", er, ec);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule